// File: doc/BRIEF.md
# Dual-Array Translation Entry Access Unit

This unit holds two arrays of translation entries. One is set-associative: 2 ways by 128 sets. The other is fully associative: 16 entries. Software reaches any single entry through five 32-bit assist registers:

- a selector register;
- a control register;
- a page register;
- a physical register;
- an extended physical register.

Software first loads the selector and page registers through the register-load port. It then pulses a command strobe. A write command stores the assist-register fields into the addressed entry. A read command fetches the addressed entry and loads its fields back into the assist registers. The read also rewrites the selector register with the reduced index that was actually used.

A single state machine sequences each command through four states:

- **IDLE** waits for a command. It moves to ACCESS when `cmd_valid` is high.
- **ACCESS** writes the addressed array, or captures the addressed entry into a holding register. It always moves to UPDATE.
- **UPDATE** loads the captured fields into the assist registers on a read. It always moves to DONE.
- **DONE** raises `done` for one cycle. It always returns to IDLE.

Register loads and commands are taken only in IDLE.

Top module: `tlb_access_unit`

## Requirements
- R1: After reset, all five assist registers read zero and every entry of both arrays is invalid with all fields zero, so reading any entry returns zero in the control, page, physical and extended registers.
- R2: In IDLE, `reg_wr_en` loads `reg_wr_data` into the register picked by `reg_wr_code` on the next clock edge. The codes are 0 selector, 1 control, 2 page, 3 physical and 4 extended. Codes 5 to 7 change no register.
- R3: A write command stores the current assist-register fields into the addressed entry. The stored fields are:
  - control: valid bit 31, process ID bits 23:16, page size bits 11:8;
  - page: page number bits 31:12, attributes bits 4:0;
  - physical: real page bits 31:12, permissions bits 5:0;
  - extended: extended real bits 3:0.
- R4: When selector bit 0 is 0, the set-associative array is addressed. The way is the entry field (selector bits 8:4) modulo 2, and the set is page-register bits 18:12.
- R5: When selector bit 0 is 1, the fully associative array is addressed by the entry field modulo 16. The page register has no effect on which entry is chosen.
- R6: A read loads the control, page and physical registers with the entry's fields at the R3 positions, with all other bits zero. It also rewrites the selector with the reduced entry number in bits 8:4, the array bit in bit 0, and zero elsewhere.
- R7: On a read, the extended register takes the entry's 4 extended real bits, zero-extended, only if `ext_update_en` is high in the UPDATE cycle. Otherwise it keeps its value.
- R8: A command sampled in IDLE raises `done` for exactly one cycle, three clock edges after the edge that accepted it. The assist registers already hold the result while `done` is high.
- R9: Commands and register loads presented while the unit is not in IDLE are ignored.
- R10: Selector bit 1 is ignored. Select value 2 behaves as 0, and 3 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Assist-register load strobe |
| reg_wr_code | input | 3 | Assist-register code |
| reg_wr_data | input | 32 | Data to load |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 = write entry, 0 = read entry |
| ext_update_en | input | 1 | Allows a read to update the extended register |
| done | output | 1 | One-cycle completion pulse |
| sel_reg | output | 32 | Selector register |
| ctl_reg | output | 32 | Control register |
| page_reg | output | 32 | Page register |
| phys_reg | output | 32 | Physical register |
| ext_reg | output | 32 | Extended physical register |

## Verification
The bench builds the unit with its defaults: 7 set-index bits, 1 way bit and 4 fully associative index bits. The 5-bit entry field is therefore wider than both arrays, so the modulo reduction on the way number and on the entry number are both reachable. Because the set index spans all 7 page-register bits, entries in neighbouring sets can be told apart. An entry with the same index in the other array can also be told apart.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int REG_W       = 32;
    localparam int PID_W       = 8;
    localparam int SIZE_W      = 4;
    localparam int PAGE_W      = 20;
    localparam int XR_W        = 4;
    localparam int ATTR_W      = 5;
    localparam int PERM_W      = 6;
    localparam int ENT_W       = 5;

    localparam int CTL_VALID_BIT = 31;
    localparam int CTL_PID_LSB   = 16;
    localparam int CTL_SIZE_LSB  = 8;
    localparam int PAGE_LSB      = 12;
    localparam int SEL_ARR_LSB   = 0;
    localparam int SEL_ENT_LSB   = 4;

    localparam logic [2:0] RC_SELECT = 3'd0;
    localparam logic [2:0] RC_CTRL   = 3'd1;
    localparam logic [2:0] RC_PAGE   = 3'd2;
    localparam logic [2:0] RC_PHYS   = 3'd3;
    localparam logic [2:0] RC_EXT    = 3'd4;

    typedef struct packed {
        logic              valid;
        logic [PID_W-1:0]  pid;
        logic [SIZE_W-1:0] psize;
        logic [PAGE_W-1:0] page;
        logic [PAGE_W-1:0] rpn;
        logic [XR_W-1:0]   xrpn;
        logic [ATTR_W-1:0] attr;
        logic [PERM_W-1:0] perm;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_UPDATE = 2'd2,
        ST_DONE   = 2'd3
    } acc_state_t;
endpackage

// File: rtl/tlb_sel_decode.sv
module tlb_sel_decode
    import tlb_pkg::*;
#(
    parameter int SET_LOG2  = 7,
    parameter int WAY_LOG2  = 1,
    parameter int FULL_LOG2 = 4
) (
    input  logic                         arr_bit,
    input  logic [ENT_W-1:0]             ent_field,
    input  logic [SET_LOG2-1:0]          set_idx,
    output logic                         use_full,
    output logic [SET_LOG2+WAY_LOG2-1:0] set_addr,
    output logic [FULL_LOG2-1:0]         full_addr,
    output logic [ENT_W-1:0]             ent_norm
);
    assign use_full  = arr_bit;
    // Power-of-two sizes: modulo reduction keeps the low bits.
    assign full_addr = ent_field[FULL_LOG2-1:0];

    generate
        if (WAY_LOG2 > 0) begin : g_multi_way
            logic [WAY_LOG2-1:0] way;
            assign way      = ent_field[WAY_LOG2-1:0];
            assign set_addr = {way, set_idx};
            assign ent_norm = use_full ? ENT_W'(full_addr) : ENT_W'(way);
        end else begin : g_single_way
            assign set_addr = set_idx;
            assign ent_norm = use_full ? ENT_W'(full_addr) : '0;
        end
    endgenerate
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  tlb_entry_t        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output tlb_entry_t        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    tlb_entry_t mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tlb_access_unit.sv
module tlb_access_unit
    import tlb_pkg::*;
#(
    parameter int SET_LOG2  = 7,
    parameter int WAY_LOG2  = 1,
    parameter int FULL_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [2:0]       reg_wr_code,
    input  logic [REG_W-1:0] reg_wr_data,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic             ext_update_en,
    output logic             done,
    output logic [REG_W-1:0] sel_reg,
    output logic [REG_W-1:0] ctl_reg,
    output logic [REG_W-1:0] page_reg,
    output logic [REG_W-1:0] phys_reg,
    output logic [REG_W-1:0] ext_reg
);
    localparam int SET_AW = SET_LOG2 + WAY_LOG2;

    acc_state_t state_q, state_d;
    logic op_write_q;
    logic [REG_W-1:0] sel_q, ctl_q, page_q, phys_q, ext_q;
    logic [REG_W-1:0] res_sel, res_ctl, res_page, res_phys, res_ext;

    logic                 use_full;
    logic [SET_AW-1:0]    set_addr;
    logic [FULL_LOG2-1:0] full_addr;
    logic [ENT_W-1:0]     ent_norm;

    tlb_entry_t wr_entry, set_rd, full_rd, rd_q;
    logic accept, set_we, full_we, load_result, reg_load_ok;

    // ---------------- selector decode ----------------
    tlb_sel_decode #(
        .SET_LOG2 (SET_LOG2),
        .WAY_LOG2 (WAY_LOG2),
        .FULL_LOG2(FULL_LOG2)
    ) u_decode (
        .arr_bit  (sel_q[SEL_ARR_LSB]),
        .ent_field(sel_q[SEL_ENT_LSB +: ENT_W]),
        .set_idx  (page_q[PAGE_LSB +: SET_LOG2]),
        .use_full (use_full),
        .set_addr (set_addr),
        .full_addr(full_addr),
        .ent_norm (ent_norm)
    );

    // ---------------- arrays ----------------
    tlb_entry_store #(.ADDR_W(SET_AW)) u_set_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (set_we),
        .wr_addr(set_addr),
        .wr_data(wr_entry),
        .rd_addr(set_addr),
        .rd_data(set_rd)
    );

    tlb_entry_store #(.ADDR_W(FULL_LOG2)) u_full_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (full_we),
        .wr_addr(full_addr),
        .wr_data(wr_entry),
        .rd_addr(full_addr),
        .rd_data(full_rd)
    );

    // ---------------- entry image from assist registers ----------------
    always_comb begin
        wr_entry       = '0;
        wr_entry.valid = ctl_q[CTL_VALID_BIT];
        wr_entry.pid   = ctl_q[CTL_PID_LSB +: PID_W];
        wr_entry.psize = ctl_q[CTL_SIZE_LSB +: SIZE_W];
        wr_entry.page  = page_q[PAGE_LSB +: PAGE_W];
        wr_entry.attr  = page_q[0 +: ATTR_W];
        wr_entry.rpn   = phys_q[PAGE_LSB +: PAGE_W];
        wr_entry.perm  = phys_q[0 +: PERM_W];
        wr_entry.xrpn  = ext_q[0 +: XR_W];
    end

    // ---------------- assist-register image from captured entry ----------------
    always_comb begin
        res_ctl  = '0;
        res_page = '0;
        res_phys = '0;
        res_ext  = '0;
        res_sel  = '0;
        res_ctl[CTL_VALID_BIT]            = rd_q.valid;
        res_ctl[CTL_PID_LSB +: PID_W]     = rd_q.pid;
        res_ctl[CTL_SIZE_LSB +: SIZE_W]   = rd_q.psize;
        res_page[PAGE_LSB +: PAGE_W]      = rd_q.page;
        res_page[0 +: ATTR_W]             = rd_q.attr;
        res_phys[PAGE_LSB +: PAGE_W]      = rd_q.rpn;
        res_phys[0 +: PERM_W]             = rd_q.perm;
        res_ext[0 +: XR_W]                = rd_q.xrpn;
        res_sel[SEL_ENT_LSB +: ENT_W]     = ent_norm;
        res_sel[SEL_ARR_LSB]              = use_full;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_valid) state_d = ST_ACCESS;
            ST_ACCESS: state_d = ST_UPDATE;
            ST_UPDATE: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- state outputs ----------------
    always_comb begin
        accept      = 1'b0;
        set_we      = 1'b0;
        full_we     = 1'b0;
        load_result = 1'b0;
        reg_load_ok = 1'b0;
        done        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept      = cmd_valid;
                reg_load_ok = reg_wr_en;
            end
            ST_ACCESS: begin
                set_we  = op_write_q && !use_full;
                full_we = op_write_q &&  use_full;
            end
            ST_UPDATE: load_result = !op_write_q;
            ST_DONE:   done = 1'b1;
        endcase
    end

    // ---------------- command capture and entry holding register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_write_q <= 1'b0;
            rd_q       <= '0;
        end else begin
            if (accept) op_write_q <= cmd_write;
            if (state_q == ST_ACCESS && !op_write_q)
                rd_q <= use_full ? full_rd : set_rd;
        end
    end

    // ---------------- assist registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            ctl_q  <= '0;
            page_q <= '0;
            phys_q <= '0;
            ext_q  <= '0;
        end else if (reg_load_ok) begin
            case (reg_wr_code)
                RC_SELECT: sel_q  <= reg_wr_data;
                RC_CTRL:   ctl_q  <= reg_wr_data;
                RC_PAGE:   page_q <= reg_wr_data;
                RC_PHYS:   phys_q <= reg_wr_data;
                RC_EXT:    ext_q  <= reg_wr_data;
                default:   ;
            endcase
        end else if (load_result) begin
            sel_q  <= res_sel;
            ctl_q  <= res_ctl;
            page_q <= res_page;
            phys_q <= res_phys;
            if (ext_update_en) ext_q <= res_ext;
        end
    end

    assign sel_reg  = sel_q;
    assign ctl_reg  = ctl_q;
    assign page_reg = page_q;
    assign phys_reg = phys_q;
    assign ext_reg  = ext_q;

    // ---------------- assertions ----------------
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_valid) |-> ##3 done);

    assert_busy_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCESS) |=> $stable({sel_q, ctl_q, page_q, phys_q, ext_q}));

    assert_ext_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UPDATE && !ext_update_en) |=> $stable(ext_q));

    assert_write_keeps_regs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UPDATE && op_write_q) |=> $stable({sel_q, ctl_q, page_q, phys_q, ext_q}));

    assert_one_array_written_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_we, full_we}));
endmodule

// File: tb/tlb_access_unit_test.sv
`timescale 1ns/1ps
module tlb_access_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_code = '0;
    logic [31:0] reg_wr_data = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic        ext_update_en = 1'b0;
    logic        done;
    logic [31:0] sel_reg, ctl_reg, page_reg, phys_reg, ext_reg;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tlb_access_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_code(reg_wr_code),
        .reg_wr_data(reg_wr_data), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .ext_update_en(ext_update_en), .done(done), .sel_reg(sel_reg), .ctl_reg(ctl_reg),
        .page_reg(page_reg), .phys_reg(phys_reg), .ext_reg(ext_reg)
    );

    typedef struct packed {
        logic       wr;
        logic [1:0] arr;
        logic [4:0] ent;
        logic [6:0] idx;
        logic [7:0] tag;
        logic [6:0] exp_idx;
        logic       exp_valid;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 2'd0, 5'd0,  7'd5,  8'h11, 7'd0, 1'b0},
        '{1'b1, 2'd0, 5'd1,  7'd5,  8'h22, 7'd0, 1'b0},
        '{1'b1, 2'd0, 5'd0,  7'd6,  8'h33, 7'd0, 1'b0},
        '{1'b1, 2'd1, 5'd3,  7'd9,  8'h44, 7'd0, 1'b0},
        '{1'b1, 2'd1, 5'd15, 7'd0,  8'h55, 7'd0, 1'b0},
        '{1'b0, 2'd0, 5'd0,  7'd5,  8'h11, 7'd5, 1'b1},
        '{1'b0, 2'd0, 5'd1,  7'd5,  8'h22, 7'd5, 1'b1},
        '{1'b0, 2'd0, 5'd0,  7'd6,  8'h33, 7'd6, 1'b1},
        '{1'b0, 2'd0, 5'd3,  7'd5,  8'h22, 7'd5, 1'b1},
        '{1'b0, 2'd1, 5'd3,  7'd77, 8'h44, 7'd9, 1'b1},
        '{1'b0, 2'd1, 5'd19, 7'd0,  8'h44, 7'd9, 1'b1},
        '{1'b0, 2'd1, 5'd15, 7'd1,  8'h55, 7'd0, 1'b1},
        '{1'b0, 2'd2, 5'd0,  7'd5,  8'h11, 7'd5, 1'b1},
        '{1'b0, 2'd3, 5'd15, 7'd3,  8'h55, 7'd0, 1'b1},
        '{1'b0, 2'd0, 5'd1,  7'd6,  8'h00, 7'd0, 1'b0},
        '{1'b0, 2'd1, 5'd0,  7'd0,  8'h00, 7'd0, 1'b0}
    };

    function automatic logic [31:0] ctl_of(input logic [7:0] t);
        return {1'b1, 7'b0, t, 4'b0, t[3:0], 8'b0};
    endfunction
    function automatic logic [31:0] phys_of(input logic [7:0] t);
        return {t, 12'hABC, 6'b0, t[5:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_reg(input logic [2:0] code, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_code = code; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic run_cmd(input logic wr);
        int guard;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr;
        @(negedge clk);
        cmd_valid = 1'b0;
        guard = 0;
        while (!done && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of assist registers
        chk("R1 sel", sel_reg, 32'h0);
        chk("R1 ctl", ctl_reg, 32'h0);
        chk("R1 page", page_reg, 32'h0);
        chk("R1 phys", phys_reg, 32'h0);
        chk("R1 ext", ext_reg, 32'h0);
        chk("R1 done", {31'b0, done}, 32'h0);

        // R2: register load and ignored codes
        load_reg(3'd1, 32'h1234_5678);
        chk("R2 ctl load", ctl_reg, 32'h1234_5678);
        load_reg(3'd7, 32'hFFFF_FFFF);
        load_reg(3'd5, 32'hFFFF_FFFF);
        chk("R2 code ignored ctl", ctl_reg, 32'h1234_5678);
        chk("R2 code ignored sel", sel_reg, 32'h0);
        chk("R2 code ignored page", page_reg, 32'h0);
        chk("R2 code ignored phys", phys_reg, 32'h0);
        chk("R2 code ignored ext", ext_reg, 32'h0);

        // Vector table: writes (R3) then reads (R4, R5, R6, R10, R1)
        ext_update_en = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            logic [4:0] red;
            string req;
            v = VECS[i];
            load_reg(3'd0, {23'b0, v.ent, 2'b0, v.arr});
            if (v.wr) begin
                load_reg(3'd1, ctl_of(v.tag));
                load_reg(3'd2, {v.tag, 5'b0, v.idx, 7'h55, v.tag[4:0]});
                load_reg(3'd3, phys_of(v.tag));
                load_reg(3'd4, {28'hABCDEF0, v.tag[3:0]});
                run_cmd(1'b1);
            end else begin
                load_reg(3'd2, {8'hEE, 5'b0, v.idx, 12'h0});
                load_reg(3'd1, 32'hDEAD_BEEF);
                load_reg(3'd3, 32'hCAFE_F00D);
                load_reg(3'd4, 32'hFFFF_FFFF);
                run_cmd(1'b0);
                red = v.arr[0] ? (v.ent & 5'h0F) : (v.ent & 5'h01);
                if (!v.exp_valid)   req = "R1";
                else if (v.arr[1])  req = "R10/R3";
                else if (v.arr[0])  req = "R5/R3";
                else                req = "R4/R3";
                chk($sformatf("R6 sel vec %0d", i), sel_reg, {23'b0, red, 3'b0, v.arr[0]});
                if (v.exp_valid) begin
                    chk($sformatf("%s ctl vec %0d", req, i), ctl_reg, ctl_of(v.tag));
                    chk($sformatf("%s page vec %0d", req, i), page_reg,
                        {v.tag, 5'b0, v.exp_idx, 7'b0, v.tag[4:0]});
                    chk($sformatf("%s phys vec %0d", req, i), phys_reg, phys_of(v.tag));
                    chk($sformatf("R7 ext vec %0d", i), ext_reg, {28'b0, v.tag[3:0]});
                end else begin
                    chk($sformatf("%s ctl vec %0d", req, i), ctl_reg, 32'h0);
                    chk($sformatf("%s page vec %0d", req, i), page_reg, 32'h0);
                    chk($sformatf("%s phys vec %0d", req, i), phys_reg, 32'h0);
                    chk($sformatf("%s ext vec %0d", req, i), ext_reg, 32'h0);
                end
            end
        end

        // R7: extended register held when update disabled
        ext_update_en = 1'b0;
        load_reg(3'd0, 32'h0000_0031);
        load_reg(3'd4, 32'h0000_0123);
        run_cmd(1'b0);
        chk("R7 ext held", ext_reg, 32'h0000_0123);
        chk("R7 ctl still loaded", ctl_reg, ctl_of(8'h44));

        // R8 / R9: timing of done, and busy-time inputs ignored
        ext_update_en = 1'b1;
        load_reg(3'd0, 32'h0000_0031);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b0;
        @(negedge clk);
        chk("R8 done low +1", {31'b0, done}, 32'h0);
        cmd_write = 1'b1;
        reg_wr_en = 1'b1; reg_wr_code = 3'd0; reg_wr_data = 32'h0000_01F0;
        @(negedge clk);
        cmd_valid = 1'b0; reg_wr_en = 1'b0;
        chk("R8 done low +2", {31'b0, done}, 32'h0);
        @(negedge clk);
        chk("R8 done high +3", {31'b0, done}, 32'h1);
        chk("R8 result ready", ctl_reg, ctl_of(8'h44));
        chk("R9 sel load ignored", sel_reg, 32'h0000_0031);
        @(negedge clk);
        chk("R8 done one cycle", {31'b0, done}, 32'h0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R9 busy command ignored", {31'b0, done}, 32'h0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule